// File: doc/BRIEF.md
# Data Lane High-Speed Burst Sequencer

This block steps one data lane of a dual-mode serial transmitter through a complete high-speed burst. The lane rests in the low-power stop state. When a burst is requested and the clock lane reports that it has been running long enough, the lane issues the low-power request state. It then drives the low-power bridge state. After that it drives the high-speed zero state, sends a single sync byte, streams payload bytes taken through a valid/ready handshake, and drives a trail in which every bit is the inverse of the final payload bit. It then returns to stop and holds there for a minimum exit period.

Every interval is a programmable count of clock cycles. A count of zero is handled as one cycle. Any low-power interval is stretched to at least the low-power minimum length. The encoded line state and the byte for the serializer go to a downstream serializer and line driver, which are not part of this block. A one-cycle end-of-transmission pulse marks the return to stop. If the payload stream runs dry before the last byte has been accepted, an error pulse is raised and the burst is closed with a trail.

Top module: `lane_burst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `line_state` is 0 (LP-11 stop), `tx_ready`, `eot` and `gap_err` are 0, and `ser_byte` is 8'h00.
- R2: A burst begins only from stop, and only when `burst_req` and `clk_lane_ok` are both 1 at a clock edge. `line_state` becomes 1 (LP-01 request) in the following cycle. While `clk_lane_ok` is 0 the lane stays at 0.
- R3: Code 1 (request) lasts exactly max(1, `cfg_lpx`) cycles.
- R4: Code 2 (LP-00 bridge) lasts exactly max(1, `cfg_lpx`, `cfg_prepare`) cycles.
- R5: Code 3 (HS-0) lasts exactly max(1, `cfg_zero`) cycles. It is followed by exactly one cycle of code 4 (HS data) with `ser_byte` = 8'hB8, the sync byte, whose bits go out LSB first.
- R6: `tx_ready` is 1 in the sync cycle and in each later data cycle until a byte flagged `tx_last` has been accepted. A byte accepted at an edge appears on `ser_byte` in the next cycle. With k bytes, code 4 lasts k+1 cycles.
- R7: After the data cycles, code 5 (HS trail) lasts exactly max(1, `cfg_trail`) cycles. During it, every bit of `ser_byte` equals the inverse of bit 7 of the final byte sent.
- R8: `eot` is 1 for exactly one cycle: the first cycle of code 0 after the trail.
- R9: After a burst the lane holds code 0 for max(1, `cfg_exit`, `cfg_lpx`) cycles before a new request is taken. With `burst_req` held at 1, code 1 appears again exactly one cycle after that.
- R10: If `tx_ready` is 1 and `tx_valid` is 0 at an edge, the burst ends. `gap_err` pulses for one cycle, coinciding with the first trail cycle. The trail inverts bit 7 of the last byte shown, which is the sync byte if no payload byte was taken. The trail and the exit period then follow normally. `gap_err` stays 0 in bursts with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_req | input | 1 | Request for a high-speed burst (level) |
| clk_lane_ok | input | 1 | Clock lane has run its pre-clock interval |
| cfg_lpx | input | CNT_W | Minimum low-power state length in cycles |
| cfg_prepare | input | CNT_W | Bridge (LP-00) interval in cycles |
| cfg_zero | input | CNT_W | HS-0 interval in cycles |
| cfg_trail | input | CNT_W | Trail interval in cycles |
| cfg_exit | input | CNT_W | Minimum stop interval after a burst |
| tx_byte | input | 8 | Payload byte |
| tx_valid | input | 1 | Payload byte is valid |
| tx_last | input | 1 | Payload byte is the final one |
| tx_ready | output | 1 | Byte accepted at this edge when valid |
| ser_byte | output | 8 | Byte for the serializer |
| line_state | output | 3 | 0 stop, 1 request, 2 bridge, 3 HS-0, 4 HS data, 5 HS trail |
| eot | output | 1 | End-of-transmission pulse |
| gap_err | output | 1 | Payload ran dry before the last byte |

## Verification
The state and the outputs are all registered, so each result falls in a known cycle. A request sampled at an edge shows as code 1 in the next cycle. A byte accepted at an edge shows on `ser_byte` one cycle later. `eot` and `gap_err` rise in the first cycle of the phase they mark. The bench samples on the falling edge. It records, for each cycle, the code on the line and, in data and trail cycles, the byte. It compares the run length of each code and each byte's position against the values the requirements give. It also counts the cycles from the `eot` cycle to the next request, which ties the exit window to an exact cycle count.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [2:0] {
    LS_STOP   = 3'd0,
    LS_REQ    = 3'd1,
    LS_BRIDGE = 3'd2,
    LS_HS0    = 3'd3,
    LS_HSDATA = 3'd4,
    LS_TRAIL  = 3'd5
  } line_e;

  typedef enum logic [2:0] {
    S_STOP,
    S_REQ,
    S_BRIDGE,
    S_HS0,
    S_SYNC,
    S_PAY,
    S_TRAIL,
    S_EXIT
  } seq_e;

  localparam logic [7:0] SYNC_BYTE = 8'hB8;

endpackage

// File: rtl/lbs_timer.sv
module lbs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // the state is left in the cycle where cnt+1 reaches the limit; a zero limit behaves as one
  always_comb begin
    done = ({1'b0, cnt_q} + EXT_W'(1)) >= {1'b0, limit};
  end

  always_comb begin
    cnt_en = clr || !done;
    cnt_d  = clr ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_req,
  input  logic             clk_lane_ok,
  input  logic [CNT_W-1:0] cfg_lpx,
  input  logic [CNT_W-1:0] cfg_prepare,
  input  logic [CNT_W-1:0] cfg_zero,
  input  logic [CNT_W-1:0] cfg_trail,
  input  logic [CNT_W-1:0] cfg_exit,
  input  logic             pay_stop,
  input  logic             tmr_done,
  output logic [CNT_W-1:0] tmr_limit,
  output logic             tmr_clr,
  output seq_e             st_q,
  output seq_e             st_d
);

  logic [CNT_W-1:0] bridge_len;
  logic [CNT_W-1:0] exit_len;

  // low-power intervals never fall below the minimum low-power length
  always_comb begin
    bridge_len = (cfg_prepare > cfg_lpx) ? cfg_prepare : cfg_lpx;
    exit_len   = (cfg_exit    > cfg_lpx) ? cfg_exit    : cfg_lpx;
  end

  always_comb begin
    unique case (st_q)
      S_REQ:    tmr_limit = cfg_lpx;
      S_BRIDGE: tmr_limit = bridge_len;
      S_HS0:    tmr_limit = cfg_zero;
      S_TRAIL:  tmr_limit = cfg_trail;
      S_EXIT:   tmr_limit = exit_len;
      default:  tmr_limit = '0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_STOP:   if (burst_req && clk_lane_ok) st_d = S_REQ;
      S_REQ:    if (tmr_done) st_d = S_BRIDGE;
      S_BRIDGE: if (tmr_done) st_d = S_HS0;
      S_HS0:    if (tmr_done) st_d = S_SYNC;
      S_SYNC:   st_d = pay_stop ? S_TRAIL : S_PAY;
      S_PAY:    if (pay_stop) st_d = S_TRAIL;
      S_TRAIL:  if (tmr_done) st_d = S_EXIT;
      S_EXIT:   if (tmr_done) st_d = S_STOP;
      default:  st_d = S_STOP;
    endcase
  end

  always_comb begin
    tmr_clr = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_STOP;
    end else begin
      st_q <= st_d;
    end
  end

  // R2: no request may leave stop unless the clock lane is ready
  a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP && !clk_lane_ok) |=> (st_q == S_STOP));

  // R5: HS-0 is entered only from the bridge state
  a_r5_hs0_after_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HS0 && $past(st_q) != S_HS0) |-> ($past(st_q) == S_BRIDGE));

endmodule

// File: rtl/lbs_datapath.sv
module lbs_datapath
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_e       st_q,
  input  seq_e       st_d,
  input  logic [7:0] tx_byte,
  input  logic       tx_valid,
  input  logic       tx_last,
  output logic       tx_ready,
  output logic       pay_stop,
  output logic [7:0] ser_byte,
  output logic       eot,
  output logic       gap_err
);

  logic [7:0] byte_q, byte_d;
  logic       last_q, last_d;
  logic       eot_d, gap_d;
  logic       in_window;
  logic       take;

  always_comb begin
    in_window = (st_q == S_SYNC) || (st_q == S_PAY);
    tx_ready  = in_window && !last_q;
    take      = tx_ready && tx_valid;
    pay_stop  = in_window && (last_q || !tx_valid);
  end

  always_comb begin
    byte_d = byte_q;
    last_d = last_q;
    if (st_d == S_SYNC && st_q != S_SYNC) begin
      byte_d = SYNC_BYTE;
      last_d = 1'b0;
    end else if (take) begin
      byte_d = tx_byte;
      last_d = tx_last;
    end else if (st_d == S_TRAIL && st_q != S_TRAIL) begin
      byte_d = {8{~byte_q[7]}};
    end else if (st_d == S_EXIT && st_q != S_EXIT) begin
      byte_d = 8'h00;
      last_d = 1'b0;
    end
    eot_d = (st_q == S_TRAIL) && (st_d == S_EXIT);
    gap_d = tx_ready && !tx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= 8'h00;
      last_q  <= 1'b0;
      eot     <= 1'b0;
      gap_err <= 1'b0;
    end else begin
      byte_q  <= byte_d;
      last_q  <= last_d;
      eot     <= eot_d;
      gap_err <= gap_d;
    end
  end

  assign ser_byte = byte_q;

  // R6: once a final byte is taken, no further byte is offered for
  a_r6_ready_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid && tx_last) |=> !tx_ready);

endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq
  import lbs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_req,
  input  logic             clk_lane_ok,
  input  logic [CNT_W-1:0] cfg_lpx,
  input  logic [CNT_W-1:0] cfg_prepare,
  input  logic [CNT_W-1:0] cfg_zero,
  input  logic [CNT_W-1:0] cfg_trail,
  input  logic [CNT_W-1:0] cfg_exit,
  input  logic [7:0]       tx_byte,
  input  logic             tx_valid,
  input  logic             tx_last,
  output logic             tx_ready,
  output logic [7:0]       ser_byte,
  output logic [2:0]       line_state,
  output logic             eot,
  output logic             gap_err
);

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] tmr_limit;
  logic             tmr_clr, tmr_done, pay_stop;
  line_e            ls;

  lbs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  lbs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_req   (burst_req),
    .clk_lane_ok (clk_lane_ok),
    .cfg_lpx     (cfg_lpx),
    .cfg_prepare (cfg_prepare),
    .cfg_zero    (cfg_zero),
    .cfg_trail   (cfg_trail),
    .cfg_exit    (cfg_exit),
    .pay_stop    (pay_stop),
    .tmr_done    (tmr_done),
    .tmr_limit   (tmr_limit),
    .tmr_clr     (tmr_clr),
    .st_q        (st_q),
    .st_d        (st_d)
  );

  lbs_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_q     (st_q),
    .st_d     (st_d),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .tx_ready (tx_ready),
    .pay_stop (pay_stop),
    .ser_byte (ser_byte),
    .eot      (eot),
    .gap_err  (gap_err)
  );

  always_comb begin
    unique case (st_q)
      S_REQ:          ls = LS_REQ;
      S_BRIDGE:       ls = LS_BRIDGE;
      S_HS0:          ls = LS_HS0;
      S_SYNC, S_PAY:  ls = LS_HSDATA;
      S_TRAIL:        ls = LS_TRAIL;
      default:        ls = LS_STOP;
    endcase
  end

  assign line_state = ls;

  // R5: the first data cycle after HS-0 carries the sync byte
  a_r5_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_HSDATA && $past(line_state) == LS_HS0) |-> (ser_byte == SYNC_BYTE));

  // R7: the trail inverts the final bit of the last byte sent
  a_r7_trail_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_TRAIL && $past(line_state) == LS_HSDATA) |->
      (ser_byte == {8{~$past(ser_byte[7])}}));

  // R8: end-of-transmission marks the step from trail back to stop
  a_r8_eot_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (line_state == LS_STOP && $past(line_state) == LS_TRAIL));

  // R10: a gap error always lands in the trail
  a_r10_gap_in_trail: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> (line_state == LS_TRAIL));

  // R2: while the clock lane is not ready the line stays in stop
  a_r2_line_stays_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == LS_STOP && !clk_lane_ok) |=> (line_state == LS_STOP));

endmodule

// File: tb/tb_lane_burst_seq.sv
module tb_lane_burst_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       burst_req, clk_lane_ok;
  logic [7:0] cfg_lpx, cfg_prepare, cfg_zero, cfg_trail, cfg_exit;
  logic [7:0] tx_byte;
  logic       tx_valid, tx_last;
  logic       tx_ready;
  logic [7:0] ser_byte;
  logic [2:0] line_state;
  logic       eot, gap_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lane_burst_seq #(.CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .clk_lane_ok(clk_lane_ok),
    .cfg_lpx(cfg_lpx), .cfg_prepare(cfg_prepare), .cfg_zero(cfg_zero),
    .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .ser_byte(ser_byte), .line_state(line_state),
    .eot(eot), .gap_err(gap_err)
  );

  // fields: lpx, prepare, zero, trail, exit, payload bytes
  localparam int NV = 6;
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'd2, 8'd3, 8'd4, 8'd3, 8'd5, 8'd3},
    {8'd4, 8'd2, 8'd1, 8'd2, 8'd2, 8'd1},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2},
    {8'd1, 8'd6, 8'd7, 8'd1, 8'd9, 8'd4},
    {8'd3, 8'd3, 8'd2, 8'd5, 8'd1, 8'd5},
    {8'd5, 8'd1, 8'd3, 8'd2, 8'd6, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m1(input int a);
    return (a < 1) ? 1 : a;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] pay(input int v, input int j);
    return 8'((v * 37) + (j * 13) + 5 + ((j % 2) * 128));
  endfunction

  task automatic set_cfg(input int l, input int p, input int z, input int t, input int e);
    cfg_lpx = 8'(l); cfg_prepare = 8'(p); cfg_zero = 8'(z);
    cfg_trail = 8'(t); cfg_exit = 8'(e);
  endtask

  task automatic settle();
    tx_valid = 1'b0; tx_last = 1'b0; burst_req = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic run_vec(input int v);
    int l, p, z, t, e, k;
    int cnt[6];
    int bursts, idx, pos, gap, bad_bytes, bad_trail, errs_seen;
    bit acc, gap_on;
    logic [2:0] prev;
    logic [7:0] trail_exp;
    {l, p, z, t, e, k} = {24'd0, VEC[v][47:40], 24'd0, VEC[v][39:32], 24'd0, VEC[v][31:24],
                          24'd0, VEC[v][23:16], 24'd0, VEC[v][15:8], 24'd0, VEC[v][7:0]};
    set_cfg(l, p, z, t, e);
    for (int s = 0; s < 6; s++) cnt[s] = 0;
    bursts = 0; idx = 0; pos = 0; gap = 0; bad_bytes = 0; bad_trail = 0; errs_seen = 0;
    acc = 1'b0; gap_on = 1'b0; prev = 3'd0;
    trail_exp = {8{~pay(v, k - 1)[7]}};
    burst_req = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (acc) idx++;
      if (line_state == 3'd1 && prev != 3'd1) begin
        bursts++; idx = 0; pos = 0;
        if (bursts == 2) begin
          burst_req = 1'b0;
          gap_on = 1'b0;
          chk(gap == mx(m1(e), m1(l)) + 1, "R9 stop cycles before next request", gap, mx(m1(e), m1(l)) + 1);
        end
      end
      if (gap_err) errs_seen++;
      if (bursts == 1) begin
        cnt[line_state]++;
        if (line_state == 3'd4) begin
          if (ser_byte != ((pos == 0) ? 8'hB8 : pay(v, pos - 1))) bad_bytes++;
          pos++;
        end
        if (line_state == 3'd5 && ser_byte != trail_exp) bad_trail++;
      end
      if (eot) begin
        chk(line_state == 3'd0 && prev == 3'd5, "R8 eot on first stop cycle after trail", line_state, 0);
        if (bursts == 1) begin
          gap_on = 1'b1;
          chk(cnt[1] == m1(l), "R3 request length", cnt[1], m1(l));
          chk(cnt[2] == mx(m1(l), m1(p)), "R4 bridge length", cnt[2], mx(m1(l), m1(p)));
          chk(cnt[3] == m1(z), "R5 HS-0 length", cnt[3], m1(z));
          chk(cnt[4] == k + 1, "R6 data cycles", cnt[4], k + 1);
          chk(bad_bytes == 0, "R5/R6 sync and payload bytes", bad_bytes, 0);
          chk(cnt[5] == m1(t), "R7 trail length", cnt[5], m1(t));
          chk(bad_trail == 0, "R7 trail byte", bad_trail, 0);
        end else begin
          break;
        end
      end
      if (gap_on && line_state == 3'd0) gap++;
      if (bursts >= 1 && idx < k) begin
        tx_valid = 1'b1; tx_byte = pay(v, idx); tx_last = (idx == k - 1);
      end else begin
        tx_valid = 1'b0; tx_last = 1'b0;
      end
      acc = tx_ready && tx_valid;
      prev = line_state;
    end
    chk(bursts == 2, "R9 second burst taken", bursts, 2);
    chk(errs_seen == 0, "R10 no gap error without a gap", errs_seen, 0);
    settle();
  endtask

  task automatic run_gap(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] texp);
    int idx, hs, pulses, eots;
    bit acc, first_trail_ok, seen_trail;
    logic [2:0] prev;
    set_cfg(2, 2, 2, 3, 2);
    idx = 0; hs = 0; pulses = 0; eots = 0; acc = 1'b0;
    first_trail_ok = 1'b0; seen_trail = 1'b0; prev = 3'd0;
    burst_req = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (acc) idx++;
      if (line_state == 3'd1) burst_req = 1'b0;
      if (line_state == 3'd4) hs++;
      if (gap_err) pulses++;
      if (line_state == 3'd5 && prev != 3'd5) begin
        seen_trail = 1'b1;
        first_trail_ok = gap_err;
        chk(ser_byte == texp, "R10 trail byte after gap", ser_byte, texp);
      end
      if (eot) begin eots++; break; end
      if (idx < nb) begin
        tx_valid = 1'b1; tx_byte = (idx == 0) ? b0 : b1; tx_last = 1'b0;
      end else begin
        tx_valid = 1'b0; tx_last = 1'b0;
      end
      acc = tx_ready && tx_valid;
      prev = line_state;
    end
    chk(hs == nb + 1, "R10 data cycles before gap", hs, nb + 1);
    chk(seen_trail && first_trail_ok, "R10 gap_err on first trail cycle", first_trail_ok, 1);
    chk(pulses == 1, "R10 single gap_err pulse", pulses, 1);
    chk(eots == 1, "R10 burst closes with eot", eots, 1);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int held;
    rst_n = 1'b0; burst_req = 1'b0; clk_lane_ok = 1'b0;
    tx_byte = 8'h00; tx_valid = 1'b0; tx_last = 1'b0;
    set_cfg(2, 2, 2, 2, 2);
    repeat (3) @(negedge clk);
    chk(line_state == 3'd0 && !tx_ready && !eot && !gap_err && ser_byte == 8'h00,
        "R1 state under reset", line_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_state == 3'd0 && !tx_ready && !eot && !gap_err && ser_byte == 8'h00,
        "R1 state after reset", line_state, 0);

    // R2: request held while the clock lane is not ready
    burst_req = 1'b1;
    held = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (line_state != 3'd0) held++;
    end
    chk(held == 0, "R2 no start without clock lane", held, 0);
    clk_lane_ok = 1'b1;
    @(negedge clk);
    chk(line_state == 3'd1, "R2 request one cycle after grant", line_state, 1);
    burst_req = 1'b0;
    tx_valid = 1'b1; tx_last = 1'b1; tx_byte = 8'h3C;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (eot) break;
    end
    settle();

    for (int v = 0; v < NV; v++) run_vec(v);

    run_gap(2, 8'h12, 8'h80, 8'h00);
    run_gap(2, 8'h12, 8'h05, 8'hFF);
    run_gap(0, 8'h00, 8'h00, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule